// File: doc/BRIEF.md
# Mailbox Boot Loader

This block is the receiving end of a four-port byte mailbox shared with a host processor. Each port holds two 8-bit registers: one the host writes and the loader reads, one the loader writes and the host reads. Out of reset the loader shows a fixed ready pattern. The host then streams a block of bytes into the loader's local RAM. The host paces every byte by waiting until the loader echoes back the sequence value it placed on port 0.

A block opens with a kick token. The host puts a 16-bit destination on ports 2 and 3, a nonzero byte on port 1 and the token 0xCC on port 0. Each byte after that travels on port 1 with an 8-bit running index on port 0. The loader writes the byte to base plus a 16-bit byte counter. To close the stream, the host skips one index value. If port 1 then holds zero, ports 2 and 3 carry the program entry address, the loader raises a one-cycle start pulse and goes silent. If port 1 is nonzero, a new block begins at the address on ports 2 and 3.

Top module: `mbox_boot_loader`

## Requirements
- R1: After reset the outgoing port 0 reads 0xAA, outgoing port 1 reads 0xBB, the 16-bit host read of ports 0 and 1 (port 0 in the low byte) gives 0xBBAA, and there is no RAM write and no start pulse.
- R2: While idle, a change of incoming port 0 to 0xCC latches the base address from incoming ports 2 (low byte) and 3 (high byte), and 0xCC appears on outgoing port 0 one clock after the host write.
- R3: During a transfer, a change of incoming port 0 to the expected index (0 for the first byte) writes the port 1 byte to RAM at base plus the byte counter and echoes the index on outgoing port 0, both one clock after the host write.
- R4: The index advances modulo 256, while the RAM address is the 16-bit sum of base and a 16-bit byte counter, which wraps modulo 65536.
- R5: A change of incoming port 0 to any value other than the one expected in the current phase causes no RAM write and leaves outgoing port 0 unchanged.
- R6: Rewriting incoming port 0 with the value it already holds causes no action, and writing ports 1 to 3 alone causes no action.
- R7: During a transfer, port 0 set to the expected index plus 1 with port 1 equal to zero echoes that value, outputs the entry address from ports 2 (low) and 3 (high), and raises the start pulse for exactly one clock, all one clock after the host write.
- R8: During a transfer, port 0 set to the expected index plus 1 with port 1 nonzero echoes that value and starts a new block at the base on ports 2 and 3, with the expected index and the byte counter back at 0.
- R9: After the start pulse, no host write causes any RAM write, echo change or further pulse.
- R10: Host write select n (0 to 3) writes incoming port n. Host read select n returns outgoing port n. Outgoing ports 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for one incoming port |
| hostWrSel | input | 2 | Incoming port number being written |
| hostWrData | input | 8 | Byte written by the host |
| hostRdSel | input | 2 | Outgoing port number being read |
| hostRdByte | output | 8 | Selected outgoing port |
| hostRdPair | output | 16 | Outgoing ports 1 (high) and 0 (low) as one word |
| ramWe | output | 1 | Local RAM write enable |
| ramAddr | output | 16 | Local RAM write address |
| ramWdata | output | 8 | Local RAM write data |
| entryAddr | output | 16 | Program entry address reported at the end of the load |
| startPulse | output | 1 | One-cycle start strobe |

## Verification
Each result is due a fixed two clock edges after the host write is driven. The first edge captures the write in the incoming port, and the second makes the loader's echo, RAM write, entry address and start pulse visible. The driver writes on a falling edge and samples the echo one full clock after the write edge. The scoreboard monitor compares every RAM write on the falling edge where it is due, and any write it did not expect counts as a mismatch. This makes the ignored stimuli observable. The start pulse is sampled on its due edge and on the edge after it.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_PORTS = 4;
  localparam int SEL_W     = $clog2(NUM_PORTS);
  localparam int ADDR_W    = 2 * BYTE_W;

  typedef struct packed {
    logic latchBase;
    logic writeByte;
    logic finish;
  } mblStrobeT;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} mblStateT;
endpackage

// File: rtl/mbl_ctrl.sv
module mbl_ctrl
  import mbl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] KICK_TOKEN = 8'hCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] in0,
  input  logic [BYTE_W-1:0] in1,
  output mblStrobeT         strb
);
  mblStateT          state, nextState;
  logic [BYTE_W-1:0] expIdx, nextIdx, lastIn0;
  logic              fresh;

  assign fresh = (in0 != lastIn0);

  always_comb begin
    strb      = '0;
    nextState = state;
    nextIdx   = expIdx;
    case (state)
      ST_IDLE: begin
        if (fresh && in0 == KICK_TOKEN) begin
          strb.latchBase = 1'b1;
          nextState      = ST_XFER;
          nextIdx        = '0;
        end
      end
      ST_XFER: begin
        if (fresh && in0 == expIdx) begin
          strb.writeByte = 1'b1;
          nextIdx        = expIdx + 1'b1;
        end else if (fresh && in0 == expIdx + 1'b1) begin
          if (in1 == '0) begin
            strb.finish = 1'b1;
            nextState   = ST_DONE;
          end else begin
            strb.latchBase = 1'b1;
            nextIdx        = '0;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      expIdx  <= '0;
      lastIn0 <= '0;
    end else begin
      state   <= nextState;
      expIdx  <= nextIdx;
      lastIn0 <= in0;
    end
  end

  // R2/R3/R7: at most one action per cycle
  a_r3_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.latchBase, strb.writeByte, strb.finish}));

  // R9: once finished, the loader stays finished and quiet
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE |=> state == ST_DONE && strb == '0);

  // R6: an unchanged port 0 never triggers an action
  a_r6_needs_change: assert property (@(posedge clk) disable iff (!rstN)
    !fresh |-> strb == '0);
endmodule

// File: rtl/mbl_datapath.sv
module mbl_datapath
  import mbl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] READY_LO = 8'hAA,
  parameter logic [BYTE_W-1:0] READY_HI = 8'hBB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [SEL_W-1:0]  hostWrSel,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [SEL_W-1:0]  hostRdSel,
  output logic [BYTE_W-1:0] hostRdByte,
  output logic [ADDR_W-1:0] hostRdPair,
  input  mblStrobeT         strb,
  output logic [BYTE_W-1:0] in0,
  output logic [BYTE_W-1:0] in1,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [BYTE_W-1:0] ramWdata,
  output logic [ADDR_W-1:0] entryAddr,
  output logic              startPulse
);
  logic [NUM_PORTS-1:0][BYTE_W-1:0] inReg;
  logic [NUM_PORTS-1:0][BYTE_W-1:0] outVec;
  logic [BYTE_W-1:0]                outEcho;
  logic [ADDR_W-1:0]                baseReg, byteCount, portAddr;

  assign in0      = inReg[0];
  assign in1      = inReg[1];
  assign portAddr = {inReg[3], inReg[2]};

  // Host-written side of every mailbox port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (hostWrEn && hostWrSel == SEL_W'(p)) inReg[p] <= hostWrData;
      end
    end
  end

  // Loader-written side: port 0 echoes, port 1 holds the ready mark
  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_out
      if (g == 0) begin : g_echo
        assign outVec[g] = outEcho;
      end else if (g == 1) begin : g_mark
        assign outVec[g] = READY_HI;
      end else begin : g_zero
        assign outVec[g] = '0;
      end
    end
  endgenerate

  assign hostRdByte = outVec[hostRdSel];
  assign hostRdPair = {outVec[1], outVec[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEcho    <= READY_LO;
      baseReg    <= '0;
      byteCount  <= '0;
      ramWe      <= 1'b0;
      ramAddr    <= '0;
      ramWdata   <= '0;
      entryAddr  <= '0;
      startPulse <= 1'b0;
    end else begin
      ramWe      <= 1'b0;
      startPulse <= 1'b0;
      if (strb.latchBase) begin
        baseReg   <= portAddr;
        byteCount <= '0;
        outEcho   <= inReg[0];
      end
      if (strb.writeByte) begin
        ramWe     <= 1'b1;
        ramAddr   <= baseReg + byteCount;
        ramWdata  <= inReg[1];
        byteCount <= byteCount + 1'b1;
        outEcho   <= inReg[0];
      end
      if (strb.finish) begin
        entryAddr  <= portAddr;
        startPulse <= 1'b1;
        outEcho    <= inReg[0];
      end
    end
  end

  // R3/R4: a write strobe lands at base plus counter with the port 1 byte
  a_r4_write_target: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |=> ramWe && ramAddr == $past(baseReg + byteCount)
                      && ramWdata == $past(inReg[1]));

  // R5: without an action the echo holds
  a_r5_echo_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strb == '0 |=> $stable(outEcho));

  // R7: finish reports the entry address and a single pulse
  a_r7_entry_report: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> startPulse && entryAddr == $past(portAddr));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
endmodule

// File: rtl/mbox_boot_loader.sv
module mbox_boot_loader
  import mbl_pkg::*;
#(
  parameter logic [7:0] READY_LO   = 8'hAA,
  parameter logic [7:0] READY_HI   = 8'hBB,
  parameter logic [7:0] KICK_TOKEN = 8'hCC
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [1:0]  hostWrSel,
  input  logic [7:0]  hostWrData,
  input  logic [1:0]  hostRdSel,
  output logic [7:0]  hostRdByte,
  output logic [15:0] hostRdPair,
  output logic        ramWe,
  output logic [15:0] ramAddr,
  output logic [7:0]  ramWdata,
  output logic [15:0] entryAddr,
  output logic        startPulse
);
  mblStrobeT   strb;
  logic [7:0]  in0, in1;

  mbl_ctrl #(.KICK_TOKEN(KICK_TOKEN)) i_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .in0  (in0),
    .in1  (in1),
    .strb (strb)
  );

  mbl_datapath #(.READY_LO(READY_LO), .READY_HI(READY_HI)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEn   (hostWrEn),
    .hostWrSel  (hostWrSel),
    .hostWrData (hostWrData),
    .hostRdSel  (hostRdSel),
    .hostRdByte (hostRdByte),
    .hostRdPair (hostRdPair),
    .strb       (strb),
    .in0        (in0),
    .in1        (in1),
    .ramWe      (ramWe),
    .ramAddr    (ramAddr),
    .ramWdata   (ramWdata),
    .entryAddr  (entryAddr),
    .startPulse (startPulse)
  );

  // R9: no RAM write once the start pulse has fired
  logic started;
  always_ff @(posedge clk) begin
    if (!rstN) started <= 1'b0;
    else if (startPulse) started <= 1'b1;
  end

  a_r9_silent_after_start: assert property (@(posedge clk) disable iff (!rstN)
    started |-> !ramWe && !startPulse);
endmodule

// File: tb/test_mbox_boot_loader.sv
module test_mbox_boot_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [1:0]  hostWrSel = '0;
  logic [7:0]  hostWrData = '0;
  logic [1:0]  hostRdSel = '0;
  logic [7:0]  hostRdByte;
  logic [15:0] hostRdPair;
  logic        ramWe;
  logic [15:0] ramAddr;
  logic [7:0]  ramWdata;
  logic [15:0] entryAddr;
  logic        startPulse;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [23:0] expQ[$];

  always #10 clk = ~clk;

  mbox_boot_loader i_mbox_boot_loader (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrSel(hostWrSel),
    .hostWrData(hostWrData), .hostRdSel(hostRdSel), .hostRdByte(hostRdByte),
    .hostRdPair(hostRdPair), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .entryAddr(entryAddr), .startPulse(startPulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one host write; returns on the falling edge after the write edge
  task automatic hostWr(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrSel = sel; hostWrData = val;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  // Echo is due one clock after the write edge
  task automatic expectEcho(input logic [7:0] val, input string req);
    @(negedge clk);
    check(hostRdPair[7:0] == val, req, {24'h0, hostRdPair[7:0]}, {24'h0, val});
  endtask

  task automatic sendByte(input logic [7:0] idx, input logic [7:0] data,
                          input logic [15:0] addr, input string req);
    hostWr(2'd1, data);
    hostWr(2'd0, idx);
    expQ.push_back({addr, data});
    expectEcho(idx, req);
  endtask

  // Scoreboard monitor: every RAM write must match the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && ramWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5/R6/R9 unexpected write", {8'h0, ramAddr, ramWdata}, 32'h0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check({ramAddr, ramWdata} == e, "R3/R4 ram write",
                {8'h0, ramAddr, ramWdata}, {8'h0, e});
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] base2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 and R10: reset state
    check(hostRdPair == 16'hBBAA, "R1 ready pair", {16'h0, hostRdPair}, 32'hBBAA);
    check(!ramWe && !startPulse, "R1 quiet", {30'h0, ramWe, startPulse}, 32'h0);
    hostRdSel = 2'd1; #1;
    check(hostRdByte == 8'hBB, "R10 read sel 1", {24'h0, hostRdByte}, 32'hBB);
    hostRdSel = 2'd2; #1;
    check(hostRdByte == 8'h00, "R10 read sel 2", {24'h0, hostRdByte}, 32'h0);
    hostRdSel = 2'd0; #1;
    check(hostRdByte == 8'hAA, "R10 read sel 0", {24'h0, hostRdByte}, 32'hAA);

    // R5: wrong value while idle is ignored
    hostWr(2'd0, 8'h05);
    expectEcho(8'hAA, "R5 idle ignore");

    // R2: open block at 0x1200
    hostWr(2'd2, 8'h00);
    hostWr(2'd3, 8'h12);
    hostWr(2'd1, 8'h01);
    hostWr(2'd0, 8'hCC);
    expectEcho(8'hCC, "R2 kick echo");

    // R3: first byte
    sendByte(8'd0, 8'h3A, 16'h1200, "R3 echo idx0");
    // R6: same port 0 value again, with new port 1 data: nothing happens
    hostWr(2'd1, 8'h77);
    hostWr(2'd0, 8'd0);
    expectEcho(8'd0, "R6 no change");
    // R5: out-of-sequence index ignored
    hostWr(2'd0, 8'd3);
    expectEcho(8'd0, "R5 wrong index");
    for (int i = 1; i < 5; i++)
      sendByte(8'(i), 8'(i * 7 + 3), 16'h1200 + 16'(i), "R3 echo");

    // R8: jump by 2 with port 1 nonzero opens a new block at 0xFF80
    base2 = 16'hFF80;
    hostWr(2'd2, base2[7:0]);
    hostWr(2'd3, base2[15:8]);
    hostWr(2'd1, 8'h5E);
    hostWr(2'd0, 8'd6);
    expectEcho(8'd6, "R8 restart echo");

    // R4: 300 bytes, index wraps mod 256, address wraps mod 65536
    for (int i = 0; i < 300; i++)
      sendByte(8'(i), 8'(i ^ 8'h5A), 16'(base2 + 16'(i)), "R4 echo");

    // R7: end command, expected index 44, so write 45 with port 1 zero
    hostWr(2'd1, 8'h00);
    hostWr(2'd2, 8'h00);
    hostWr(2'd3, 8'h04);
    hostWr(2'd0, 8'd45);
    @(negedge clk);
    check(hostRdPair[7:0] == 8'd45, "R7 end echo", {24'h0, hostRdPair[7:0]}, 32'd45);
    check(startPulse == 1'b1, "R7 pulse high", {31'h0, startPulse}, 32'h1);
    check(entryAddr == 16'h0400, "R7 entry", {16'h0, entryAddr}, 32'h0400);
    @(negedge clk);
    check(startPulse == 1'b0, "R7 pulse one cycle", {31'h0, startPulse}, 32'h0);

    // R9: nothing responds afterwards
    hostWr(2'd1, 8'h11);
    hostWr(2'd0, 8'd44);
    hostWr(2'd0, 8'd46);
    hostWr(2'd0, 8'hCC);
    @(negedge clk);
    check(hostRdPair[7:0] == 8'd45, "R9 echo frozen", {24'h0, hostRdPair[7:0]}, 32'd45);
    check(!startPulse, "R9 no pulse", {31'h0, startPulse}, 32'h0);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 queue drained", expQ.size(), 32'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule